// File: doc/BRIEF.md
# Early-End Transfer Report Queue

This block keeps a record of transfers that finished before reaching their programmed length, for example when a streaming source closed its packet early. When a transfer ends, the block gets its ID, the number of bytes actually moved, an early-end indicator and the report-enable flag that the transfer was submitted with. If the transfer ended early and reporting was requested, the ID and the byte count go into a small first-in first-out store.

Software drains the store through three read-only register locations. It reads the byte count, then the ID, and repeats while the top bit of the completion word is set. Only the ID read removes an entry, so reading the byte count any number of times changes nothing.

A report that arrives while the store is full is discarded and sets a sticky overflow flag. A channel abort empties the store and clears that flag.

Top module: `partial_report_queue`

## Requirements
- R1: An entry is recorded on a clock edge only when `eot_valid`, `eot_early` and `eot_report_en` are all high and the parameter REPORT_SUPPORT is 1. A transfer end with either flag low leaves the store unchanged.
- R2: A read at address 0x44c returns the byte count of the oldest entry, zero-extended to 32 bits. It removes nothing, so repeated reads return the same value.
- R3: A read at address 0x450 returns the ID of the oldest entry, zero-extended, and removes that entry on the same clock edge. Entries come out in the order they were recorded.
- R4: A read at address 0x428 returns `done_bits` in bits 30:0, with bit 31 set while at least one entry is waiting. `pending` mirrors bit 31.
- R5: While DEPTH entries are held, a new report is discarded and `overflow` goes high on the next edge. `overflow` stays high until an abort or a reset.
- R6: `abort` empties the store and clears `overflow` on the next edge. A report arriving in the same cycle as an abort is not kept.
- R7: After reset the store is empty and both `pending` and `overflow` are low.
- R8: When the store is full and an ID read arrives in the same cycle as a new report, the oldest entry is removed, the new one is kept, and `overflow` stays low.
- R9: An ID or byte-count read while the store is empty returns zero and changes nothing.
- R10: A read at any other address, or with `rd_en` low, returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eot_valid | input | 1 | A transfer ended this cycle |
| eot_id | input | ID_W | ID of the ended transfer |
| eot_bytes | input | LEN_W | Bytes actually moved |
| eot_early | input | 1 | Transfer ended before its programmed length |
| eot_report_en | input | 1 | Transfer was submitted with reporting enabled |
| abort | input | 1 | Channel abort; flushes the store |
| done_bits | input | 31 | Completed-ID bits merged into the completion word |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 12 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| pending | output | 1 | At least one entry is waiting |
| overflow | output | 1 | Sticky flag: a report was discarded |

## Verification
Read data is combinational, so it is sampled in the same cycle as the strobe, one time step after the bench drives it. The entry removal, a newly recorded report, the flush and the overflow flag all take effect on the following rising edge, so `pending` and `overflow` are checked at the falling edge after that. The bench drives at falling edges and samples only in those two places. A reference queue in the bench mirrors every report it expects to be kept, and each ID and byte-count read is compared against the head of that queue.

// File: rtl/prq_pkg.sv
package prq_pkg;
  localparam logic [11:0] ADDR_DONE = 12'h428;
  localparam logic [11:0] ADDR_LEN  = 12'h44c;
  localparam logic [11:0] ADDR_ID   = 12'h450;

  // circular pointer advance for any depth
  function automatic int wrap_inc(int ptr, int depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction

  // completion word: pending flag on top of the completed-ID bits
  function automatic logic [31:0] done_word(logic pend, logic [30:0] bits);
    return {pend, bits};
  endfunction
endpackage

// File: rtl/prq_fifo.sv
module prq_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic                       pop,
  input  logic [W-1:0]               din,
  output logic [W-1:0]               head,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       full,
  output logic                       empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= PW'(prq_pkg::wrap_inc(int'(wr_ptr), DEPTH));
      if (pop)  rd_ptr <= PW'(prq_pkg::wrap_inc(int'(rd_ptr), DEPTH));
      case ({push, pop})
        2'b10:   level <= level + CW'(1);
        2'b01:   level <= level - CW'(1);
        default: level <= level;
      endcase
    end
  end

  assign head  = mem[rd_ptr];
  assign full  = (level == CW'(DEPTH));
  assign empty = (level == '0);
endmodule

// File: rtl/prq_readmux.sv
module prq_readmux #(
  parameter int ID_W  = 5,
  parameter int LEN_W = 24
) (
  input  logic             rd_en,
  input  logic [11:0]      rd_addr,
  input  logic             empty,
  input  logic [ID_W-1:0]  head_id,
  input  logic [LEN_W-1:0] head_len,
  input  logic [30:0]      done_bits,
  output logic [31:0]      rd_data
);
  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      case (rd_addr)
        prq_pkg::ADDR_DONE: rd_data = prq_pkg::done_word(!empty, done_bits);
        prq_pkg::ADDR_LEN:  rd_data = empty ? '0 : 32'(head_len);
        prq_pkg::ADDR_ID:   rd_data = empty ? '0 : 32'(head_id);
        default:            rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/partial_report_queue.sv
module partial_report_queue #(
  parameter int DEPTH          = 4,
  parameter int ID_W           = 5,
  parameter int LEN_W          = 24,
  parameter bit REPORT_SUPPORT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eot_valid,
  input  logic [ID_W-1:0]  eot_id,
  input  logic [LEN_W-1:0] eot_bytes,
  input  logic             eot_early,
  input  logic             eot_report_en,
  input  logic             abort,
  input  logic [30:0]      done_bits,
  input  logic             rd_en,
  input  logic [11:0]      rd_addr,
  output logic [31:0]      rd_data,
  output logic             pending,
  output logic             overflow
);
  localparam int W  = ID_W + LEN_W;
  localparam int CW = $clog2(DEPTH + 1);

  logic          want, id_read, pop_fire, push_ok, drop;
  logic          full, empty;
  logic [W-1:0]  head;
  logic [CW-1:0] level;

  generate
    if (REPORT_SUPPORT) begin : g_rep
      assign want = eot_valid && eot_early && eot_report_en;
    end else begin : g_norep
      assign want = 1'b0;
    end
  endgenerate

  assign id_read  = rd_en && (rd_addr == prq_pkg::ADDR_ID);
  assign pop_fire = id_read && !empty && !abort;
  assign push_ok  = want && !abort && (!full || pop_fire);
  assign drop     = want && !abort && full && !pop_fire;

  prq_fifo #(.DEPTH(DEPTH), .W(W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(abort),
    .push(push_ok), .pop(pop_fire), .din({eot_id, eot_bytes}),
    .head(head), .level(level), .full(full), .empty(empty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || abort) overflow <= 1'b0;
    else if (drop)       overflow <= 1'b1;
  end

  prq_readmux #(.ID_W(ID_W), .LEN_W(LEN_W)) u_rd (
    .rd_en(rd_en), .rd_addr(rd_addr), .empty(empty),
    .head_id(head[W-1:LEN_W]), .head_len(head[LEN_W-1:0]),
    .done_bits(done_bits), .rd_data(rd_data)
  );

  assign pending = !empty;
endmodule

// File: rtl/prq_checker.sv
module prq_checker #(
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          abort,
  input logic          eot_valid,
  input logic          eot_early,
  input logic          eot_report_en,
  input logic          push_ok,
  input logic          pop_fire,
  input logic          drop,
  input logic [CW-1:0] level,
  input logic          pending,
  input logic          overflow
);
  assert_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |-> (eot_valid && eot_early && eot_report_en));
  assert_pop_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire |-> pending);
  assert_push_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !abort) |=> pending);
  assert_drop_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> overflow);
  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !abort) |=> overflow);
  assert_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));
  assert_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!pending && !overflow));
endmodule

bind partial_report_queue prq_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .abort(abort), .eot_valid(eot_valid),
  .eot_early(eot_early), .eot_report_en(eot_report_en),
  .push_ok(push_ok), .pop_fire(pop_fire), .drop(drop), .level(level),
  .pending(pending), .overflow(overflow)
);

// File: tb/partial_report_queue_test.sv
module partial_report_queue_test;
  localparam int DEPTH = 4, ID_W = 5, LEN_W = 24;
  localparam logic [11:0] A_DONE = 12'h428, A_LEN = 12'h44c, A_ID = 12'h450;

  logic clk = 0, rst_n = 0;
  logic eot_valid = 0, eot_early = 0, eot_report_en = 0, abort = 0, rd_en = 0;
  logic [ID_W-1:0] eot_id = '0;
  logic [LEN_W-1:0] eot_bytes = '0;
  logic [30:0] done_bits = 31'h0000_0a05;
  logic [11:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic pending, overflow;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [31:0] exp_q[$];   // entries {id, len} packed as id<<24 | len
  bit exp_ovf = 0;

  always #5 clk = ~clk;

  partial_report_queue #(.DEPTH(DEPTH), .ID_W(ID_W), .LEN_W(LEN_W)) uut (
    .clk(clk), .rst_n(rst_n), .eot_valid(eot_valid), .eot_id(eot_id),
    .eot_bytes(eot_bytes), .eot_early(eot_early), .eot_report_en(eot_report_en),
    .abort(abort), .done_bits(done_bits), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .pending(pending), .overflow(overflow)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic status(string req);
    chk({req, " pending"}, 32'(pending), 32'(exp_q.size() != 0));
    chk({req, " overflow"}, 32'(overflow), 32'(exp_ovf));
  endtask

  // driver: presents one transfer end and updates the reference queue
  task automatic eot(logic [ID_W-1:0] id, logic [LEN_W-1:0] n, logic early, logic en);
    eot_valid = 1; eot_id = id; eot_bytes = n; eot_early = early; eot_report_en = en;
    if (early && en) begin
      if (exp_q.size() < DEPTH) exp_q.push_back({3'b0, id, n});
      else exp_ovf = 1;
    end
    @(negedge clk);
    eot_valid = 0; eot_early = 0; eot_report_en = 0;
  endtask

  // monitor side: a register read compared with the reference
  task automatic rd(string req, logic [11:0] a);
    logic [31:0] exp;
    rd_en = 1; rd_addr = a;
    #1;
    if (a == A_LEN)       exp = (exp_q.size() != 0) ? {8'b0, exp_q[0][23:0]} : 32'h0;
    else if (a == A_ID)   exp = (exp_q.size() != 0) ? 32'(exp_q[0][28:24]) : 32'h0;
    else if (a == A_DONE) exp = {exp_q.size() != 0, done_bits};
    else                  exp = 32'h0;
    chk(req, rd_data, exp);
    if (a == A_ID && exp_q.size() != 0) void'(exp_q.pop_front());
    @(negedge clk);
    rd_en = 0;
  endtask

  // R8: ID read and new report in the same cycle while full
  task automatic rd_and_eot(logic [ID_W-1:0] id, logic [LEN_W-1:0] n);
    rd_en = 1; rd_addr = A_ID;
    eot_valid = 1; eot_id = id; eot_bytes = n; eot_early = 1; eot_report_en = 1;
    #1;
    chk("R8 id read when full", rd_data, 32'(exp_q[0][28:24]));
    void'(exp_q.pop_front());
    exp_q.push_back({3'b0, id, n});
    @(negedge clk);
    rd_en = 0; eot_valid = 0; eot_early = 0; eot_report_en = 0;
  endtask

  task automatic drain(string req);
    while (exp_q.size() != 0) begin
      rd({req, " len"}, A_LEN);
      rd({req, " id"}, A_ID);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    status("R7 reset");
    rd("R4 done word after reset", A_DONE);

    // single early transfer
    eot(5'd3, 24'd100, 1, 1);
    status("R1 recorded");
    rd("R2 len first", A_LEN);
    rd("R2 len repeat", A_LEN);
    status("R2 no pop on len read");
    rd("R4 done word pending", A_DONE);
    rd("R3 id pop", A_ID);
    status("R3 after pop");

    // ignored transfer ends
    eot(5'd7, 24'd50, 0, 1);
    eot(5'd8, 24'd60, 1, 0);
    status("R1 ignored");
    rd("R9 empty len", A_LEN);
    rd("R9 empty id", A_ID);
    status("R9 after empty read");
    rd_addr = A_LEN; rd_en = 0; #1;
    chk("R10 no strobe", rd_data, 32'h0);
    rd("R10 other address", 12'h404);

    // fill and overflow
    for (int i = 0; i < DEPTH; i++) eot(5'(10 + i), 24'(1000 * (i + 1)), 1, 1);
    status("R5 full");
    eot(5'd30, 24'h00abcd, 1, 1);
    status("R5 overflow");
    drain("R3 order");
    status("R5 sticky");

    // abort flush
    eot(5'd1, 24'd11, 1, 1);
    eot(5'd2, 24'd22, 1, 1);
    abort = 1;
    eot_valid = 1; eot_id = 5'd4; eot_bytes = 24'd44; eot_early = 1; eot_report_en = 1;
    @(negedge clk);
    abort = 0; eot_valid = 0; eot_early = 0; eot_report_en = 0;
    exp_q.delete(); exp_ovf = 0;
    status("R6 flush");
    rd("R6 id after flush", A_ID);

    // simultaneous pop and push when full
    for (int i = 0; i < DEPTH; i++) eot(5'(20 + i), 24'(7 * (i + 3)), 1, 1);
    rd_and_eot(5'd31, 24'hfffffe);
    status("R8 no overflow");
    drain("R8 order");
    status("R8 drained");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule